// File: doc/BRIEF.md
# Dual-Group Tone Frequency Classifier

This block identifies which of sixteen dual-tone pairs is present on a line. It does not see the analog signal. It sees two squared bit streams that come from limiting comparators: one stream follows the low frequency group and the other follows the high frequency group. For each stream, the block counts reference-clock cycles between rising edges. It adds four consecutive full periods into one block sum. It then tests that sum against a precomputed cycle window for each of the four tones in that group.

A group is valid only while its latest block sum lies inside the accept window of a tone. The accept window is the nominal frequency ±1.5% ±2 Hz, expressed as a count of clock cycles. Anything outside that window is invalid, including the gap between the accept limit and the 3.5% rejection limit. A group also becomes invalid when its stream stops toggling. The pair flag is the logical AND of the two group valids, so it falls in the same cycle that either group is lost. The row and column indices do not change while their group stays valid.

The reference clock rate is a parameter, set by default to 3.579545 MHz. All windows and timeouts are derived from it at elaboration.

Top module: `tone_pair_classifier`

## Requirements
- R1: After reset, `pair_valid_o` is 0 and `row_o` and `col_o` are 0.
- R2: A pair of nominal tones raises `pair_valid_o` with a fixed encoding. Row index 0,1,2,3 maps to 697, 770, 852 and 941 Hz on the low stream. Column index 0,1,2,3 maps to 1209, 1336, 1477 and 1633 Hz on the high stream.
- R3: A tone that deviates from nominal by 1% in either direction is still accepted. The accept band is ±1.5% ±2 Hz.
- R4: A tone that deviates from nominal by 3.5% or more is rejected, and `pair_valid_o` stays 0.
- R5: An average that falls between the accept band and the 3.5% limit (tested at 2.5%) is treated as invalid.
- R6: A valid tone on only one of the two streams never raises `pair_valid_o`.
- R7: When one group stops, `pair_valid_o` falls with no hold-over while the other group keeps its tone. When the lost group returns, `pair_valid_o` rises again with the same indices.
- R8: Classification uses the sum of 4 consecutive full periods. A tone whose single periods alternate ±6% about the nominal period, but whose 4-period sum is nominal, is accepted.
- R9: `row_o` and `col_o` hold while `pair_valid_o` stays high. If a group moves to a different tone, that group first goes invalid, and the flag then returns with the new index.
- R10: A stream with no rising edge for longer than 1.25 times the longest accepted period of its group makes that group invalid. This includes a stream stuck high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all period counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_sq_i | input | 1 | Squared low-group signal, asynchronous to clk |
| high_sq_i | input | 1 | Squared high-group signal, asynchronous to clk |
| pair_valid_o | output | 1 | High while both groups hold a valid tone |
| row_o | output | 2 | Low-group tone index |
| col_o | output | 2 | High-group tone index |

## Verification
The bench probes both edges of the acceptance region with integer-period square waves:
- At ±1%, a design with windows that are too tight drops a legal tone.
- At 2.5% and 4%, a design with windows that are too loose accepts an off-frequency tone, or maps it to a neighbouring index.

A stimulus with alternating ±6% periods separates a true four-period sum from a classifier that looks at one period, because the single-period classifier rejects this tone. A one-group dropout, a stuck-high stream and a mid-tone frequency switch target the remaining faults:
- hold-over of the flag;
- a missing timeout, which would leave a frozen group valid forever;
- an index that changes while the flag stays high.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    localparam int NGRP      = 2;
    localparam int NTONE     = 4;
    localparam int ACC_PERMIL = 15;   // accept band, per mille of nominal
    localparam int ACC_HZ     = 2;    // accept band, fixed offset in Hz

    function automatic int tone_hz(input int grp, input int k);
        int f;
        if (grp == 0) begin
            case (k)
                0:       f = 697;
                1:       f = 770;
                2:       f = 852;
                default: f = 941;
            endcase
        end else begin
            case (k)
                0:       f = 1209;
                1:       f = 1336;
                2:       f = 1477;
                default: f = 1633;
            endcase
        end
        return f;
    endfunction

    // Smallest accepted sum of navg periods (highest accepted frequency), rounded up.
    function automatic int band_lo_sum(input longint ref_hz, input int navg, input int f_hz);
        longint num;
        longint den;
        num = longint'(navg) * ref_hz * 1000;
        den = longint'(f_hz) * (1000 + ACC_PERMIL) + longint'(ACC_HZ) * 1000;
        return int'((num + den - 1) / den);
    endfunction

    // Largest accepted sum of navg periods (lowest accepted frequency), rounded down.
    function automatic int band_hi_sum(input longint ref_hz, input int navg, input int f_hz);
        longint num;
        longint den;
        num = longint'(navg) * ref_hz * 1000;
        den = longint'(f_hz) * (1000 - ACC_PERMIL) - longint'(ACC_HZ) * 1000;
        return int'(num / den);
    endfunction

endpackage

// File: rtl/dtc_edge_sync.sv
module dtc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sq_i,
    output logic rise_o
);
    // bits [STAGES-1:0] form the synchronizer, bit STAGES holds the previous sample
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], sq_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/dtc_band_match.sv
module dtc_band_match #(
    parameter int GRP    = 0,
    parameter int REF_HZ = 3579545,
    parameter int NAVG   = 4,
    parameter int SUMW   = 16
) (
    input  logic [SUMW-1:0] sum_i,
    output logic            hit_o,
    output logic [1:0]      idx_o
);
    logic [dtc_pkg::NTONE-1:0] in_band;

    for (genvar k = 0; k < dtc_pkg::NTONE; k++) begin : g_band
        localparam int LO = dtc_pkg::band_lo_sum(longint'(REF_HZ), NAVG, dtc_pkg::tone_hz(GRP, k));
        localparam int HI = dtc_pkg::band_hi_sum(longint'(REF_HZ), NAVG, dtc_pkg::tone_hz(GRP, k));
        assign in_band[k] = (sum_i >= SUMW'(LO)) && (sum_i <= SUMW'(HI));
    end

    always_comb begin
        hit_o = 1'b0;
        idx_o = 2'd0;
        for (int k = dtc_pkg::NTONE - 1; k >= 0; k--) begin
            if (in_band[k]) begin
                hit_o = 1'b1;
                idx_o = 2'(k);
            end
        end
    end

endmodule

// File: rtl/dtc_group_track.sv
module dtc_group_track #(
    parameter int GRP    = 0,
    parameter int REF_HZ = 3579545,
    parameter int NAVG   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    output logic       valid_o,
    output logic [1:0] idx_o
);
    localparam int PMAX = dtc_pkg::band_hi_sum(longint'(REF_HZ), 1, dtc_pkg::tone_hz(GRP, 0));
    localparam int TMO  = PMAX + PMAX / 4;
    localparam int CNTW = $clog2(TMO + 2);
    localparam int SUMW = $clog2(NAVG * (TMO + 1) + 1);
    localparam int NW   = $clog2(NAVG);

    typedef struct packed {
        logic [CNTW-1:0] cnt;
        logic [SUMW-1:0] acc;
        logic [NW-1:0]   nper;
        logic            armed;
        logic            valid;
        logic [1:0]      idx;
    } trk_t;

    trk_t            st_d, st_q;
    logic [SUMW-1:0] period_w, sum_w;
    logic            hit;
    logic [1:0]      hit_idx;
    logic            blk_done;

    assign period_w = SUMW'(st_q.cnt) + SUMW'(1);
    assign sum_w    = st_q.acc + period_w;

    dtc_band_match #(
        .GRP(GRP), .REF_HZ(REF_HZ), .NAVG(NAVG), .SUMW(SUMW)
    ) u_match (
        .sum_i (sum_w),
        .hit_o (hit),
        .idx_o (hit_idx)
    );

    always_comb begin
        st_d     = st_q;
        blk_done = 1'b0;
        if (st_q.cnt >= CNTW'(TMO)) begin
            // silent too long: drop the group and restart measurement
            st_d.valid = 1'b0;
            st_d.armed = rise_i;
            st_d.cnt   = '0;
            st_d.acc   = '0;
            st_d.nper  = '0;
        end else if (rise_i) begin
            st_d.cnt = '0;
            if (!st_q.armed) begin
                st_d.armed = 1'b1;
            end else if (st_q.nper == NW'(NAVG - 1)) begin
                blk_done  = 1'b1;
                st_d.acc  = '0;
                st_d.nper = '0;
                if (!hit) begin
                    st_d.valid = 1'b0;
                end else if (st_q.valid && (st_q.idx != hit_idx)) begin
                    st_d.valid = 1'b0;        // tone changed: pass through invalid
                end else begin
                    st_d.valid = 1'b1;
                    st_d.idx   = hit_idx;
                end
            end else begin
                st_d.acc  = sum_w;
                st_d.nper = st_q.nper + NW'(1);
            end
        end else begin
            st_d.cnt = st_q.cnt + CNTW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign idx_o   = st_q.idx;

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNTW'(TMO));

    p_tmo_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNTW'(TMO)) |=> !st_q.valid);

    p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && $past(st_q.valid)) |-> $stable(st_q.idx));

    p_rise_at_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.valid) |-> $past(blk_done));

    p_nper_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.nper <= NW'(NAVG - 1));

endmodule

// File: rtl/tone_pair_classifier.sv
module tone_pair_classifier #(
    parameter int REF_HZ      = 3579545,
    parameter int NAVG        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       low_sq_i,
    input  logic       high_sq_i,
    output logic       pair_valid_o,
    output logic [1:0] row_o,
    output logic [1:0] col_o
);
    logic [dtc_pkg::NGRP-1:0] grp_valid;
    logic [1:0]               grp_idx [dtc_pkg::NGRP];

    for (genvar g = 0; g < dtc_pkg::NGRP; g++) begin : g_grp
        logic sq;
        logic rise;
        assign sq = (g == 0) ? low_sq_i : high_sq_i;

        dtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .sq_i   (sq),
            .rise_o (rise)
        );

        dtc_group_track #(.GRP(g), .REF_HZ(REF_HZ), .NAVG(NAVG)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise_i  (rise),
            .valid_o (grp_valid[g]),
            .idx_o   (grp_idx[g])
        );
    end

    assign pair_valid_o = &grp_valid;
    assign row_o        = grp_idx[0];
    assign col_o        = grp_idx[1];

    p_pair_idx_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid_o && $past(pair_valid_o)) |-> ($stable(row_o) && $stable(col_o)));

endmodule

// File: tb/tone_pair_classifier_tb_top.sv
module tone_pair_classifier_tb_top;
    localparam int REF = 3579545 / 16;   // scaled reference keeps runs short
    localparam int DET_WAIT = 2400;
    localparam int QUIET    = 900;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       low_sq = 1'b0, high_sq = 1'b0;
    logic       pair_valid;
    logic [1:0] row, col;

    int errors = 0, checks = 0;
    int lo_per = 0, hi_per = 0, lo_alt = 0, hi_alt = 0;
    bit lo_flip = 0, hi_flip = 0;
    int lp, hp;
    int stab_err = 0;
    bit done = 0;
    logic prev_valid = 1'b0;
    logic [1:0] prev_row = 2'd0, prev_col = 2'd0;

    real lo_hz [4] = '{697.0, 770.0, 852.0, 941.0};
    real hi_hz [4] = '{1209.0, 1336.0, 1477.0, 1633.0};

    always #10 clk = ~clk;

    tone_pair_classifier #(.REF_HZ(REF)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .low_sq_i     (low_sq),
        .high_sq_i    (high_sq),
        .pair_valid_o (pair_valid),
        .row_o        (row),
        .col_o        (col)
    );

    // low-group square wave source
    initial begin
        forever begin
            if (lo_per == 0) begin low_sq = 1'b0; @(negedge clk); end
            else if (lo_per < 0) begin low_sq = 1'b1; @(negedge clk); end
            else begin
                lp = lo_per + (lo_flip ? lo_alt : -lo_alt);
                lo_flip = !lo_flip;
                low_sq = 1'b1; repeat (lp / 2) @(negedge clk);
                low_sq = 1'b0; repeat (lp - lp / 2) @(negedge clk);
            end
        end
    end

    // high-group square wave source
    initial begin
        forever begin
            if (hi_per == 0) begin high_sq = 1'b0; @(negedge clk); end
            else if (hi_per < 0) begin high_sq = 1'b1; @(negedge clk); end
            else begin
                hp = hi_per + (hi_flip ? hi_alt : -hi_alt);
                hi_flip = !hi_flip;
                high_sq = 1'b1; repeat (hp / 2) @(negedge clk);
                high_sq = 1'b0; repeat (hp - hp / 2) @(negedge clk);
            end
        end
    end

    // index stability monitor (R9)
    always @(negedge clk) begin
        if (rst_n && pair_valid && prev_valid && (row != prev_row || col != prev_col))
            stab_err++;
        prev_valid = pair_valid;
        prev_row   = row;
        prev_col   = col;
    end

    function automatic int per_of(input real hz);
        return $rtoi(REF / hz + 0.5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic quiet();
        lo_per = 0; hi_per = 0; lo_alt = 0; hi_alt = 0;
        repeat (QUIET) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        check(pair_valid == 1'b0, "R1 flag", int'(pair_valid), 0);
        check(row == 2'd0, "R1 row", int'(row), 0);
        check(col == 2'd0, "R1 col", int'(col), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_all_pairs();
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                quiet();
                lo_per = per_of(lo_hz[r]); hi_per = per_of(hi_hz[c]);
                repeat (DET_WAIT) @(negedge clk);
                check(pair_valid == 1'b1, "R2 flag", int'(pair_valid), 1);
                check(row == 2'(r), "R2 row", int'(row), r);
                check(col == 2'(c), "R2 col", int'(col), c);
            end
        end
    endtask

    task automatic t_accept_edges();
        quiet();
        lo_per = per_of(lo_hz[0] * 0.99); hi_per = per_of(hi_hz[3] * 1.01);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b1, "R3 flag -1%/+1%", int'(pair_valid), 1);
        check(row == 2'd0 && col == 2'd3, "R3 idx", int'({row, col}), 3);
        quiet();
        lo_per = per_of(lo_hz[3] * 1.01); hi_per = per_of(hi_hz[0] * 0.99);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b1, "R3 flag +1%/-1%", int'(pair_valid), 1);
        check(row == 2'd3 && col == 2'd0, "R3 idx", int'({row, col}), 12);
    endtask

    task automatic t_reject_far();
        quiet();
        lo_per = per_of(lo_hz[0] * 1.04); hi_per = per_of(hi_hz[2]);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b0, "R4 low +4%", int'(pair_valid), 0);
        quiet();
        lo_per = per_of(lo_hz[1]); hi_per = per_of(hi_hz[1] * 0.96);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b0, "R4 high -4%", int'(pair_valid), 0);
    endtask

    task automatic t_gap();
        quiet();
        lo_per = per_of(lo_hz[2] * 1.025); hi_per = per_of(hi_hz[0]);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b0, "R5 low +2.5%", int'(pair_valid), 0);
        quiet();
        lo_per = per_of(lo_hz[0]); hi_per = per_of(hi_hz[3] * 1.025);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b0, "R5 high +2.5%", int'(pair_valid), 0);
    endtask

    task automatic t_single_group();
        quiet();
        lo_per = per_of(lo_hz[1]);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b0, "R6 low only", int'(pair_valid), 0);
        quiet();
        hi_per = per_of(hi_hz[2]);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b0, "R6 high only", int'(pair_valid), 0);
    endtask

    task automatic t_dropout();
        quiet();
        lo_per = per_of(lo_hz[1]); hi_per = per_of(hi_hz[2]);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b1, "R7 before drop", int'(pair_valid), 1);
        hi_per = 0;
        repeat (500) @(negedge clk);
        check(pair_valid == 1'b0, "R7 high lost", int'(pair_valid), 0);
        hi_per = per_of(hi_hz[2]);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b1, "R7 restored", int'(pair_valid), 1);
        check(row == 2'd1 && col == 2'd2, "R7 idx", int'({row, col}), 6);
    endtask

    task automatic t_average();
        quiet();
        lo_per = per_of(lo_hz[1]); lo_alt = lo_per * 6 / 100;
        hi_per = per_of(hi_hz[0]);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b1, "R8 jittered periods", int'(pair_valid), 1);
        check(row == 2'd1, "R8 row", int'(row), 1);
        lo_alt = 0;
    endtask

    task automatic t_switch();
        quiet();
        lo_per = per_of(lo_hz[0]); hi_per = per_of(hi_hz[1]);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b1 && row == 2'd0, "R9 first tone", int'({pair_valid, row}), 4);
        stab_err = 0;
        lo_per = per_of(lo_hz[2]);
        repeat (4000) @(negedge clk);
        check(pair_valid == 1'b1, "R9 flag after switch", int'(pair_valid), 1);
        check(row == 2'd2, "R9 new row", int'(row), 2);
        check(stab_err == 0, "R9 index moved under flag", stab_err, 0);
    endtask

    task automatic t_stuck();
        quiet();
        lo_per = per_of(lo_hz[3]); hi_per = per_of(hi_hz[3]);
        repeat (DET_WAIT) @(negedge clk);
        check(pair_valid == 1'b1, "R10 before stall", int'(pair_valid), 1);
        lo_per = -1;
        repeat (QUIET) @(negedge clk);
        check(pair_valid == 1'b0, "R10 stuck high low group", int'(pair_valid), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_all_pairs();
        t_accept_edges();
        t_reject_far();
        t_gap();
        t_single_group();
        t_dropout();
        t_average();
        t_switch();
        t_stuck();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule